// File: doc/BRIEF.md
# Key-Sequence Watchdog Timer

This block is a watchdog for a small processor core. It counts machine-cycle ticks in a 14-bit counter and, when the counter runs out, emits a reset pulse of fixed length measured in clock periods. Software reaches it only through a byte-wide, write-only register port. One two-byte key sequence, sent to a single register address, both switches the watchdog on and services it afterwards. Once the watchdog is running, software has no way to stop it. Only a reset, or the watchdog's own expiry, returns it to the off state.

Two low-power conditions come from the surrounding core. An idle indication, combined with a pause-enable control bit, decides whether counting continues while the core idles. A power-down indication always freezes the count. The count itself is never visible on the port.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the watchdog is off: `rst_out` is low and ticks produce no pulse.
- R2: A write of 0x1E to address 0xA6, followed as the next write by 0xE1 to address 0xA6, switches the watchdog on with a count of zero. The 16383rd counted tick brings the count to 0x3FFF, and `rst_out` rises one clock after that tick's edge.
- R3: The same key pair sent while the watchdog is on clears the count to zero, so the next pulse comes 16383 counted ticks after the service.
- R4: After 0x1E, any write that is not 0xE1 to address 0xA6 cancels the sequence, whatever its address. A lone 0xE1 has no effect.
- R5: Each expiry drives `rst_out` high for exactly 98 consecutive clock cycles.
- R6: An expiry switches the watchdog off, so no further pulse follows until a new key pair is written.
- R7: With `idle_pause_en` at 0, ticks are counted while `idle_mode` is high.
- R8: With `idle_pause_en` at 1, ticks are not counted while `idle_mode` is high. Counting resumes when idle ends.
- R9: While `pwr_down` is high, ticks are not counted.
- R10: Writes to any address other than 0xA6, made while no key sequence is pending, have no effect on the count or the on/off state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_tick | input | 1 | One-clock strobe per machine cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| idle_mode | input | 1 | Core is in idle |
| idle_pause_en | input | 1 | Control bit: hold the count during idle |
| pwr_down | input | 1 | Core is powered down; the count is frozen |
| rst_out | output | 1 | Watchdog reset pulse |

## Verification
The assertions assume three things about the inputs:
- `cyc_tick` is a single-clock strobe.
- A key pair is not sent in the clock where the count sits at its maximum.
- The pulse is not re-armed while it is still high.

The stimulus keeps to these. It puts random gaps between ticks and random writes to addresses other than 0xA6. Key bytes are sent only in tick-free cycles, and each expiry is observed to its end before the next sequence is written.

// File: rtl/keyed_watchdog_pkg.sv
// Package: shared constants and the key-sequence state type.
// Assumes: consumers take defaults from here and may override them per instance.
package keyed_watchdog_pkg;
    localparam int          DEF_CNT_W      = 14;
    localparam int          DEF_PULSE_CLKS = 98;
    localparam logic [7:0]  DEF_REG_ADDR   = 8'hA6;
    localparam logic [7:0]  DEF_KEY_FIRST  = 8'h1E;
    localparam logic [7:0]  DEF_KEY_SECOND = 8'hE1;

    typedef enum logic [0:0] {
        KEY_WAIT  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_e;
endpackage

// File: rtl/keyed_watchdog_seq.sv
// Module: detects the two-byte key written to the watchdog address.
// It raises key_fire for one clock when the second byte directly follows the first.
// Assumes: one write per clock at most; any write while armed ends the arming.
module keyed_watchdog_seq
    import keyed_watchdog_pkg::*;
#(
    parameter logic [7:0] REG_ADDR   = DEF_REG_ADDR,
    parameter logic [7:0] KEY_FIRST  = DEF_KEY_FIRST,
    parameter logic [7:0] KEY_SECOND = DEF_KEY_SECOND
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       key_fire
);
    key_state_e state_q, state_d;
    logic       hit_first, hit_second;

    // Decode the two key bytes at the watchdog address.
    always_comb begin
        hit_first  = wr_en && (wr_addr == REG_ADDR) && (wr_data == KEY_FIRST);
        hit_second = wr_en && (wr_addr == REG_ADDR) && (wr_data == KEY_SECOND);
    end

    // Next-state: arm on the first byte; any later write disarms.
    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            if (state_q == KEY_ARMED) state_d = KEY_WAIT;
            else if (hit_first)       state_d = KEY_ARMED;
        end
    end

    // Fire only when the armed state meets the second byte.
    always_comb key_fire = (state_q == KEY_ARMED) && hit_second;

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KEY_WAIT;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/keyed_watchdog_cnt.sv
// Module: the on/off flag and the tick counter.
// A key switches the watchdog on, or clears the count when already on; expiry switches it off.
// Assumes: tick is a single-clock strobe; expiry takes priority over a key in the same clock.
module keyed_watchdog_cnt #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             idle_mode,
    input  logic             idle_pause_en,
    input  logic             pwr_down,
    input  logic             key_fire,
    output logic             wdt_on,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic advance;

    // A tick counts unless power-down or paused idle holds it.
    always_comb advance = tick && !pwr_down && !(idle_mode && idle_pause_en);

    // Expiry is the count sitting at all ones while on.
    always_comb expire = wdt_on && (cnt_q == CNT_MAX);

    // On/off flag and counter update, expiry first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdt_on <= 1'b0;
            cnt_q  <= '0;
        end else if (expire) begin
            wdt_on <= 1'b0;
            cnt_q  <= '0;
        end else if (key_fire) begin
            wdt_on <= 1'b1;
            cnt_q  <= '0;
        end else if (wdt_on && advance) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/keyed_watchdog_pulse.sv
// Module: stretches a one-clock expiry strobe into a reset pulse of PULSE_CLKS clocks.
// Assumes: a new expiry does not arrive while a pulse is still running.
module keyed_watchdog_pulse #(
    parameter int PULSE_CLKS = 98
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    output logic rst_out
);
    localparam int PW = (PULSE_CLKS < 2) ? 1 : $clog2(PULSE_CLKS + 1);

    generate
        if (PULSE_CLKS == 1) begin : g_single
            logic pulse_q;
            // Single-clock pulse: a delayed copy of the strobe.
            always_ff @(posedge clk) begin
                if (!rst_n) pulse_q <= 1'b0;
                else        pulse_q <= expire;
            end
            always_comb rst_out = pulse_q;
        end else begin : g_count
            logic [PW-1:0] left_q;
            // Load the width on expiry, then count down to zero.
            always_ff @(posedge clk) begin
                if (!rst_n)           left_q <= '0;
                else if (expire)      left_q <= PW'(PULSE_CLKS);
                else if (left_q != 0) left_q <= left_q - 1'b1;
            end
            always_comb rst_out = (left_q != '0);
        end
    endgenerate
endmodule

// File: rtl/keyed_watchdog.sv
// Module: top of the key-sequence watchdog.
// It joins the key detector, the counter and the pulse stretcher.
// Assumes: the write port has no read side and the count is never exposed.
module keyed_watchdog
    import keyed_watchdog_pkg::*;
#(
    parameter int         CNT_W      = DEF_CNT_W,
    parameter int         PULSE_CLKS = DEF_PULSE_CLKS,
    parameter logic [7:0] REG_ADDR   = DEF_REG_ADDR,
    parameter logic [7:0] KEY_FIRST  = DEF_KEY_FIRST,
    parameter logic [7:0] KEY_SECOND = DEF_KEY_SECOND
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_tick,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       idle_mode,
    input  logic       idle_pause_en,
    input  logic       pwr_down,
    output logic       rst_out
);
    logic             key_fire;
    logic             wdt_on;
    logic [CNT_W-1:0] cnt_q;
    logic             expire;

    keyed_watchdog_seq #(
        .REG_ADDR(REG_ADDR), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .key_fire(key_fire)
    );

    keyed_watchdog_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(cyc_tick), .idle_mode(idle_mode),
        .idle_pause_en(idle_pause_en), .pwr_down(pwr_down), .key_fire(key_fire),
        .wdt_on(wdt_on), .cnt_q(cnt_q), .expire(expire)
    );

    keyed_watchdog_pulse #(.PULSE_CLKS(PULSE_CLKS)) u_pulse (
        .clk(clk), .rst_n(rst_n), .expire(expire), .rst_out(rst_out)
    );
endmodule

// File: rtl/keyed_watchdog_chk.sv
// Module: assertion checker bound into keyed_watchdog.
// Assumes: the input rules given in the brief; it observes only and drives nothing.
module keyed_watchdog_chk #(
    parameter int CNT_W      = 14,
    parameter int PULSE_CLKS = 98
) (
    input logic             clk,
    input logic             rst_n,
    input logic             idle_mode,
    input logic             idle_pause_en,
    input logic             pwr_down,
    input logic             rst_out,
    input logic             wdt_on,
    input logic [CNT_W-1:0] cnt,
    input logic             fire
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    int hi_cnt;

    // Length of the current high run on rst_out.
    always_ff @(posedge clk) begin
        if (!rst_n)       hi_cnt <= 0;
        else if (rst_out) hi_cnt <= hi_cnt + 1;
        else              hi_cnt <= 0;
    end

    a_r1_off_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !wdt_on |-> (cnt == '0));

    a_r2_pulse_after_max: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out) |-> $past(cnt == CNT_MAX));

    a_r3_service_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && wdt_on && cnt != CNT_MAX) |=> (cnt == '0));

    a_r5_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out) |-> (hi_cnt == PULSE_CLKS));

    a_r6_expiry_turns_off: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_on && cnt == CNT_MAX) |=> !wdt_on);

    a_r8_idle_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_mode && idle_pause_en && !fire && cnt != CNT_MAX) |=> $stable(cnt));

    a_r9_pwr_down_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down && !fire && cnt != CNT_MAX) |=> $stable(cnt));
endmodule

bind keyed_watchdog keyed_watchdog_chk #(.CNT_W(CNT_W), .PULSE_CLKS(PULSE_CLKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .idle_mode(idle_mode), .idle_pause_en(idle_pause_en),
    .pwr_down(pwr_down), .rst_out(rst_out), .wdt_on(wdt_on), .cnt(cnt_q), .fire(key_fire)
);

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;
    localparam int         FULL    = 16383;
    localparam int         WIDTH   = 98;
    localparam logic [7:0] WD_ADDR = 8'hA6;

    logic       clk = 1'b0, rst_n = 1'b0, cyc_tick = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_addr = '0, wr_data = '0;
    logic       idle_mode = 1'b0, idle_pause_en = 1'b0, pwr_down = 1'b0;
    logic       rst_out;

    int  total = 0, bad = 0, pulses = 0;
    logic prev_rst = 1'b0;
    bit  done = 1'b0;

    keyed_watchdog u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .idle_mode(idle_mode),
        .idle_pause_en(idle_pause_en), .pwr_down(pwr_down), .rst_out(rst_out)
    );

    always #2 clk = ~clk;

    // Count rising edges of the reset pulse.
    always @(posedge clk) begin
        if (rst_out && !prev_rst) pulses = pulses + 1;
        prev_rst = rst_out;
    end

    function automatic logic [7:0] other_addr(input logic [7:0] a);
        return (a == WD_ADDR) ? 8'h00 : a;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        cyc_tick = 1'b0;
        wr_en    = ($urandom_range(0, 3) == 0);
        wr_addr  = other_addr(8'($urandom_range(0, 255)));
        wr_data  = 8'($urandom_range(0, 255));
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            if ($urandom_range(0, 3) == 0) idle_cycle();
            @(negedge clk);
            cyc_tick = 1'b1;
            wr_en    = 1'b0;
        end
        @(negedge clk);
        cyc_tick = 1'b0;
        wr_en    = 1'b0;
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cyc_tick = 1'b0;
        wr_en    = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        @(negedge clk);
        wr_en    = 1'b0;
    endtask

    task automatic send_key();
        write_reg(WD_ADDR, 8'h1E);
        write_reg(WD_ADDR, 8'hE1);
    endtask

    // Apply the final tick and measure the pulse cycle by cycle.
    task automatic expect_pulse(input string req);
        int w;
        run_ticks(1);
        check(rst_out == 1'b0, req, rst_out, 0);
        @(negedge clk);
        check(rst_out == 1'b1, req, rst_out, 1);
        w = 0;
        while (rst_out && w < 300) begin
            w++;
            @(negedge clk);
        end
        check(w == WIDTH, "R5", w, WIDTH);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int p0;
        void'($urandom(32'h0BAD5EED));
        repeat (5) @(negedge clk);
        check(rst_out == 1'b0, "R1", rst_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rst_out == 1'b0, "R1", rst_out, 0);

        // R1: off after reset, ticks give no pulse.
        run_ticks(3000);
        check(pulses == 0, "R1", pulses, 0);

        // R2 / R5: enable and run to expiry.
        send_key();
        run_ticks(FULL - 1);
        check(pulses == 0, "R2", pulses, 0);
        expect_pulse("R2");

        // R6 / R4: off after expiry; broken sequences must not enable.
        p0 = pulses;
        write_reg(WD_ADDR, 8'hE1);
        write_reg(WD_ADDR, 8'h1E); write_reg(WD_ADDR, 8'h55);
        write_reg(WD_ADDR, 8'h1E); write_reg(8'h20, 8'hE1); write_reg(WD_ADDR, 8'hE1);
        write_reg(WD_ADDR, 8'h1E); write_reg(WD_ADDR, 8'h1E); write_reg(WD_ADDR, 8'hE1);
        run_ticks(FULL + 20);
        check(pulses == p0, "R4", pulses, p0);
        check(pulses == p0, "R6", pulses, p0);

        // R3 / R10: service mid-run, with random foreign writes in between.
        send_key();
        run_ticks(9000);
        send_key();
        run_ticks(FULL - 1);
        check(pulses == p0, "R3", pulses, p0);
        check(pulses == p0, "R10", pulses, p0);
        expect_pulse("R3");

        // R9, R8, R7: held counts, then counting in unpaused idle.
        p0 = pulses;
        send_key();
        pwr_down = 1'b1;
        run_ticks(4000);
        pwr_down = 1'b0;
        idle_mode = 1'b1;
        idle_pause_en = 1'b1;
        run_ticks(4000);
        check(pulses == p0, "R9", pulses, p0);
        idle_pause_en = 1'b0;
        run_ticks(FULL - 1);
        check(pulses == p0, "R8", pulses, p0);
        expect_pulse("R7");
        idle_mode = 1'b0;
        check(pulses == p0 + 1, "R7", pulses, p0 + 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule